// File: doc/BRIEF.md
# Serial Flash Write Guard

This block sits after the instruction decoder of a serial NOR flash model and decides, one instruction at a time, whether a decoded instruction may run. Each instruction arrives as a one-cycle strobe carrying a 4-bit opcode and a 24-bit target address. One cycle later the block answers with exactly one pulse: accept or reject. It owns the write-enable latch, a warm-up timer that blocks every modifying instruction for a set number of cycles after the supply becomes good, and the low-power sleep state.

It also reads the status-register lock mode and the block-protection fields, which come in as levels from the status register held elsewhere. With these it judges whether a status write is allowed, given the level of the hardware write-protect pin. It also judges whether the target of a program or erase lies in the read-only region.

The control core is a two-state machine. `ST_AWAKE` is normal operation. `ST_ASLEEP` is the low-power mode. The transition *enter-sleep* (`ST_AWAKE` to `ST_ASLEEP`) is taken on an accepted sleep instruction. The transition *wake* (`ST_ASLEEP` to `ST_AWAKE`) is taken on an accepted wake instruction. A low power-good forces the machine to `ST_AWAKE` through the *power-loss* transition.

Opcodes: 1 set-write-enable, 2 clear-write-enable, 3 read, 4 page program, 5 sector erase, 6 block erase, 7 full-array erase, 8 status write, 9 sleep, 10 wake. Codes 0 and 11 to 15 are unassigned.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While `pwr_good` is low the block is held in reset. One cycle after any clock edge with `pwr_good` low, `cmd_accept`, `cmd_reject`, `wel` and `pwr_down` are all 0, whatever instructions are strobed.
- R2: After `pwr_good` rises, opcodes 1, 4, 5, 6, 7 and 8 are rejected when sampled at any of the first `PUW_CYCLES` clock edges with `pwr_good` high. They can be accepted from edge `PUW_CYCLES`+1 on. Opcodes 2, 3 and 9 are accepted inside this window.
- R3: An accepted opcode 1 sets `wel` to 1. Opcode 2 is always accepted while awake and clears `wel`.
- R4: Opcodes 4 to 8 are rejected while `wel` is 0. A rejected instruction leaves `wel` unchanged, and an accepted program, erase or status write does not itself change `wel`.
- R5: An `op_done` pulse clears `wel` at the next edge. If an opcode 1 is accepted in the same cycle, `wel` ends at 1.
- R6: An accepted opcode 9 sets `pwr_down`. While `pwr_down` is 1, every opcode other than 10 is rejected and changes neither `wel` nor the mode. Opcode 10 is accepted and clears `pwr_down`. While awake, opcode 10 is accepted with no effect.
- R7: The status write (opcode 8) also depends on `sr_lock`. 00 always permits it. 01 permits it only while `wp_pin` is 1. 10 and 11 always refuse it. The block-protection fields have no effect on opcode 8.
- R8: Opcodes 4, 5 and 6 are rejected when `cmd_addr` lies in the protected window; `sr_lock` and `wp_pin` do not affect them. The window size depends on `bp_span`: 0 means no window and 7 means the whole array. With `bp_fine`=0, values 1 to 6 give 64 KB times 2^(`bp_span`-1). With `bp_fine`=1, they give 4 KB times 2^(min(`bp_span`,4)-1). The window sits at the top of the address space when `bp_bottom`=0 and at address 0 when `bp_bottom`=1.
- R9: `bp_invert`=1 makes the protected set the complement of the window described in R8.
- R10: Opcode 7 is accepted only when nothing is protected: `bp_invert`=0 with `bp_span`=0, or `bp_invert`=1 with `bp_span`=7.
- R11: Every edge that samples `cmd_valid` high with `pwr_good` high yields exactly one one-cycle pulse on `cmd_accept` or `cmd_reject` after that edge. Without `cmd_valid`, neither pulses. Unassigned opcodes are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply-good level; low holds the block in reset |
| cmd_valid | input | 1 | One-cycle strobe of a decoded instruction |
| cmd_op | input | 4 | Decoded opcode (encoding in the description) |
| cmd_addr | input | ADDR_W | Target address of the instruction |
| op_done | input | 1 | Completion pulse of a program, erase or status write |
| wp_pin | input | 1 | Hardware write-protect level, high means writes may proceed |
| sr_lock | input | 2 | Status-register lock mode |
| bp_invert | input | 1 | Complement the protected set |
| bp_fine | input | 1 | Window counted in 4 KB sectors instead of 64 KB blocks |
| bp_bottom | input | 1 | Window at the bottom of the address space |
| bp_span | input | 3 | Window size code |
| cmd_accept | output | 1 | Pulse: last instruction accepted |
| cmd_reject | output | 1 | Pulse: last instruction refused |
| wel | output | 1 | Write-enable latch |
| pwr_down | output | 1 | Sleep mode flag |

## Verification
The hardest situation to reach is the exact edge of the warm-up window. It exists only right after power-good rises, so every other test runs after it has closed. The stimulus therefore drops power-good in the middle of the run, counts clock edges from the rise, and strobes set-write-enable at edge `PUW_CYCLES` and again at the next edge, expecting a reject and then an accept. Protection-window edges are reached through a vector table. Each vector arms the latch first, so that only the protection rule can refuse the instruction under test. Each vector also places an address one byte inside and one byte outside a window boundary.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [3:0] {
        OP_NONE      = 4'd0,
        OP_WR_EN     = 4'd1,
        OP_WR_DIS    = 4'd2,
        OP_READ      = 4'd3,
        OP_PROG      = 4'd4,
        OP_ERASE_SEC = 4'd5,
        OP_ERASE_BLK = 4'd6,
        OP_ERASE_ALL = 4'd7,
        OP_STATUS_WR = 4'd8,
        OP_SLEEP     = 4'd9,
        OP_WAKE      = 4'd10
    } op_e;

    typedef enum logic {
        ST_AWAKE  = 1'b0,
        ST_ASLEEP = 1'b1
    } pstate_e;

    // opcodes that modify the array or status register (need the latch)
    function automatic logic needs_latch(input logic [3:0] op);
        return (op >= OP_PROG) && (op <= OP_STATUS_WR);
    endfunction

    // opcodes blocked during warm-up
    function automatic logic warmup_blocked(input logic [3:0] op);
        return (op == OP_WR_EN) || needs_latch(op);
    endfunction

endpackage

// File: rtl/wp_warmup.sv
module wp_warmup #(
    parameter int PUW_CYCLES = 1000
) (
    input  logic clk,
    input  logic pwr_good,
    output logic ready
);
    localparam int CW = $clog2(PUW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PUW_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = (cnt_q == LIMIT);

endmodule

// File: rtl/wp_region.sv
module wp_region #(
    parameter int ADDR_W       = 24,
    parameter int BLOCK_LOG2   = 16,
    parameter int SECTOR_LOG2  = 12,
    parameter int SECTOR_STEPS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              invert,
    input  logic              fine,
    input  logic              bottom,
    input  logic [2:0]        span,
    output logic              addr_locked,
    output logic              any_locked
);
    localparam int LW = $clog2(ADDR_W + 1) + 1;
    localparam logic [3:0] STEP_CAP = 4'(SECTOR_STEPS - 1);

    logic [3:0]        step;
    logic [LW-1:0]     size_log2;
    logic [ADDR_W-1:0] high_mask;
    logic              empty;
    logic              in_window;

    always_comb begin
        empty = (span == 3'd0);
        step  = 4'(span) - 4'd1;
        if (fine && (step > STEP_CAP)) begin
            step = STEP_CAP;
        end
        if (span == 3'd7) begin
            size_log2 = LW'(ADDR_W);
        end else if (fine) begin
            size_log2 = LW'(SECTOR_LOG2) + LW'(step);
        end else begin
            size_log2 = LW'(BLOCK_LOG2) + LW'(step);
        end
        // bits above the window size; all-zero for a full-array window
        high_mask = ~((ADDR_W'(1) << size_log2) - ADDR_W'(1));
        if (empty) begin
            in_window = 1'b0;
        end else if (bottom) begin
            in_window = ((addr & high_mask) == '0);
        end else begin
            in_window = ((addr & high_mask) == high_mask);
        end
        addr_locked = in_window ^ invert;
        any_locked  = invert ? (span != 3'd7) : (span != 3'd0);
    end

endmodule

// File: rtl/wp_status_gate.sv
module wp_status_gate (
    input  logic [1:0] lock_mode,
    input  logic       wp_level,
    output logic       open
);
    always_comb begin
        unique case (lock_mode)
            2'b00:   open = 1'b1;
            2'b01:   open = wp_level;
            default: open = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int PUW_CYCLES   = 1000,
    parameter int BLOCK_LOG2   = 16,
    parameter int SECTOR_LOG2  = 12,
    parameter int SECTOR_STEPS = 4
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              op_done,
    input  logic              wp_pin,
    input  logic [1:0]        sr_lock,
    input  logic              bp_invert,
    input  logic              bp_fine,
    input  logic              bp_bottom,
    input  logic [2:0]        bp_span,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              wel,
    output logic              pwr_down
);

    pstate_e st_q, st_nx;
    logic    wel_q, wel_nx;
    logic    acc_q, rej_q;
    logic    take, refuse;
    logic    warm, addr_locked, any_locked, sr_open;

    wp_warmup #(.PUW_CYCLES(PUW_CYCLES)) u_warm (
        .clk      (clk),
        .pwr_good (pwr_good),
        .ready    (warm)
    );

    wp_region #(
        .ADDR_W       (ADDR_W),
        .BLOCK_LOG2   (BLOCK_LOG2),
        .SECTOR_LOG2  (SECTOR_LOG2),
        .SECTOR_STEPS (SECTOR_STEPS)
    ) u_region (
        .addr        (cmd_addr),
        .invert      (bp_invert),
        .fine        (bp_fine),
        .bottom      (bp_bottom),
        .span        (bp_span),
        .addr_locked (addr_locked),
        .any_locked  (any_locked)
    );

    wp_status_gate u_sr (
        .lock_mode (sr_lock),
        .wp_level  (wp_pin),
        .open      (sr_open)
    );

    // decision and next-state logic
    always_comb begin
        st_nx  = st_q;
        wel_nx = op_done ? 1'b0 : wel_q;
        take   = 1'b0;
        refuse = 1'b0;
        if (cmd_valid) begin
            unique case (st_q)
                ST_ASLEEP: begin
                    if (cmd_op == OP_WAKE) begin
                        take  = 1'b1;
                        st_nx = ST_AWAKE;
                    end
                end
                ST_AWAKE: begin
                    case (cmd_op)
                        OP_WR_EN: begin
                            take = warm;
                            if (warm) wel_nx = 1'b1;
                        end
                        OP_WR_DIS: begin
                            take   = 1'b1;
                            wel_nx = 1'b0;
                        end
                        OP_READ, OP_WAKE: take = 1'b1;
                        OP_SLEEP: begin
                            take  = 1'b1;
                            st_nx = ST_ASLEEP;
                        end
                        OP_PROG, OP_ERASE_SEC, OP_ERASE_BLK:
                            take = warm && wel_q && !addr_locked;
                        OP_ERASE_ALL:
                            take = warm && wel_q && !any_locked;
                        OP_STATUS_WR:
                            take = warm && wel_q && sr_open;
                        default: take = 1'b0;
                    endcase
                end
            endcase
            refuse = !take;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            st_q <= ST_AWAKE;
        end else begin
            st_q <= st_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            wel_q <= 1'b0;
            acc_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            wel_q <= wel_nx;
            acc_q <= take;
            rej_q <= refuse;
        end
    end

    assign cmd_accept = acc_q;
    assign cmd_reject = rej_q;
    assign wel        = wel_q;
    assign pwr_down   = (st_q == ST_ASLEEP);

endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk #(
    parameter int PUW_CYCLES = 1000
) (
    input logic       clk,
    input logic       pwr_good,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       op_done,
    input logic [1:0] sr_lock,
    input logic       cmd_accept,
    input logic       cmd_reject,
    input logic       wel,
    input logic       pwr_down
);
    localparam int CW = $clog2(PUW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PUW_CYCLES);

    logic [CW-1:0] since_up;

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            since_up <= '0;
        end else if (since_up != LIMIT) begin
            since_up <= since_up + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !pwr_good |=> (!cmd_accept && !cmd_reject && !wel && !pwr_down));

    a_r2_warmup_block: assert property (@(posedge clk) disable iff (!pwr_good)
        (cmd_valid && (cmd_op inside {4'd1, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8})
         && (since_up != LIMIT)) |=> !cmd_accept);

    a_r4_latch_needed: assert property (@(posedge clk) disable iff (!pwr_good)
        (cmd_valid && (cmd_op inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd8}) && !wel)
        |=> !cmd_accept);

    a_r5_done_clears: assert property (@(posedge clk) disable iff (!pwr_good)
        (op_done && !(cmd_valid && cmd_op == 4'd1 && !pwr_down)) |=> !wel);

    a_r6_sleep_refuse: assert property (@(posedge clk) disable iff (!pwr_good)
        (pwr_down && cmd_valid && cmd_op != 4'd10) |=> (cmd_reject && pwr_down));

    a_r7_sr_locked: assert property (@(posedge clk) disable iff (!pwr_good)
        (cmd_valid && cmd_op == 4'd8 && (sr_lock inside {2'b10, 2'b11}))
        |=> !cmd_accept);

    a_r11_one_answer: assert property (@(posedge clk) disable iff (!pwr_good)
        cmd_valid |=> (cmd_accept ^ cmd_reject));

    a_r11_no_answer: assert property (@(posedge clk) disable iff (!pwr_good)
        !cmd_valid |=> (!cmd_accept && !cmd_reject));

endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.PUW_CYCLES(PUW_CYCLES)) u_chk (.*);

// File: tb/sim_flash_wp_ctrl.sv
module sim_flash_wp_ctrl;

    localparam int PUW = 16;

    logic        clk = 1'b0;
    logic        pwr_good = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [23:0] cmd_addr = 24'd0;
    logic        op_done = 1'b0;
    logic        wp_pin = 1'b1;
    logic [1:0]  sr_lock = 2'b00;
    logic        bp_invert = 1'b0;
    logic        bp_fine = 1'b0;
    logic        bp_bottom = 1'b0;
    logic [2:0]  bp_span = 3'd0;
    logic        cmd_accept, cmd_reject, wel, pwr_down;

    int n_run = 0;
    int n_fail = 0;
    bit ended = 1'b0;
    logic got_acc, got_rej;

    always #5 clk = ~clk;

    flash_wp_ctrl #(.PUW_CYCLES(PUW)) u0 (
        .clk(clk), .pwr_good(pwr_good), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .op_done(op_done), .wp_pin(wp_pin), .sr_lock(sr_lock),
        .bp_invert(bp_invert), .bp_fine(bp_fine), .bp_bottom(bp_bottom),
        .bp_span(bp_span), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .wel(wel), .pwr_down(pwr_down)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [23:0] addr;
        logic        wp;
        logic [1:0]  srl;
        logic        inv;
        logic        fine;
        logic        bot;
        logic [2:0]  span;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd4, 24'h000000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd8},
        '{4'd4, 24'hFF0000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 4'd8},
        '{4'd4, 24'hFEFFFF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 4'd8},
        '{4'd5, 24'h001000, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 4'd8},
        '{4'd5, 24'h000FFF, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 4'd8},
        '{4'd6, 24'h7FFFFF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 4'd8},
        '{4'd6, 24'h123456, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 3'd7, 1'b1, 4'd9},
        '{4'd4, 24'h000000, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 4'd9},
        '{4'd4, 24'hFF1234, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 4'd9},
        '{4'd7, 24'h000000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd10},
        '{4'd7, 24'h000000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 4'd10},
        '{4'd7, 24'h000000, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 4'd10},
        '{4'd8, 24'h000000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 4'd7},
        '{4'd8, 24'h000000, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},
        '{4'd8, 24'h000000, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd7},
        '{4'd8, 24'h000000, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},
        '{4'd8, 24'h000000, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},
        '{4'd5, 24'h007FFF, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 3'd6, 1'b0, 4'd8},
        '{4'd5, 24'h008000, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 4'd8},
        '{4'd4, 24'hE00000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd6, 1'b0, 4'd8},
        '{4'd4, 24'hDFFFFF, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd6, 1'b1, 4'd8},
        '{4'd6, 24'h01FFFF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 4'd8},
        '{4'd6, 24'h020000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 4'd8}
    };

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, want, $time);
        end
    endtask

    // called at a falling edge; drives one strobe, samples at the next falling edge
    task automatic issue(input logic [3:0] op, input logic [23:0] addr);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        @(negedge clk);
        got_acc   = cmd_accept;
        got_rej   = cmd_reject;
        cmd_valid = 1'b0;
    endtask

    task automatic verdict(input string tag, input logic want_acc);
        check(tag, {30'd0, got_acc, got_rej}, {30'd0, want_acc, !want_acc});
    endtask

    task automatic done_pulse();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_fail++;
        n_run++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset holds everything low, strobes ignored
        repeat (3) @(negedge clk);
        issue(4'd1, 24'd0);
        check("R1 reset outputs", {28'd0, got_acc, got_rej, wel, pwr_down}, 32'd0);
        issue(4'd9, 24'd0);
        check("R1 no sleep in reset", {31'd0, pwr_down}, 32'd0);

        // R2: warm-up window
        pwr_good = 1'b1;
        issue(4'd1, 24'd0);
        verdict("R2 set-enable in warm-up", 1'b0);
        check("R2 latch stays low", {31'd0, wel}, 32'd0);
        issue(4'd4, 24'd0);
        verdict("R2 program in warm-up", 1'b0);
        issue(4'd3, 24'd0);
        verdict("R2 read in warm-up", 1'b1);
        issue(4'd2, 24'd0);
        verdict("R2 clear-enable in warm-up", 1'b1);
        repeat (PUW + 2) @(negedge clk);

        // R4: program without latch
        issue(4'd4, 24'd0);
        verdict("R4 program without latch", 1'b0);
        check("R4 latch unchanged", {31'd0, wel}, 32'd0);
        // R3: set and clear latch
        issue(4'd1, 24'd0);
        verdict("R3 set-enable", 1'b1);
        check("R3 latch set", {31'd0, wel}, 32'd1);
        issue(4'd2, 24'd0);
        verdict("R3 clear-enable", 1'b1);
        check("R3 latch cleared", {31'd0, wel}, 32'd0);

        // R5: completion clears latch, same-cycle set wins
        issue(4'd1, 24'd0);
        done_pulse();
        check("R5 done clears latch", {31'd0, wel}, 32'd0);
        op_done = 1'b1;
        issue(4'd1, 24'd0);
        op_done = 1'b0;
        check("R5 set wins over done", {31'd0, wel}, 32'd1);

        // R6: sleep mode
        issue(4'd9, 24'd0);
        verdict("R6 sleep accepted", 1'b1);
        check("R6 sleep flag", {31'd0, pwr_down}, 32'd1);
        issue(4'd2, 24'd0);
        verdict("R6 clear-enable ignored asleep", 1'b0);
        check("R6 latch kept asleep", {31'd0, wel}, 32'd1);
        issue(4'd3, 24'd0);
        verdict("R6 read refused asleep", 1'b0);
        issue(4'd9, 24'd0);
        verdict("R6 sleep refused asleep", 1'b0);
        issue(4'd10, 24'd0);
        verdict("R6 wake accepted", 1'b1);
        check("R6 awake again", {31'd0, pwr_down}, 32'd0);
        issue(4'd10, 24'd0);
        verdict("R6 wake while awake", 1'b1);
        check("R6 wake no effect", {30'd0, wel, pwr_down}, 32'd2);
        issue(4'd2, 24'd0);

        // R11: unassigned opcodes and idle
        issue(4'd0, 24'd0);
        verdict("R11 opcode 0", 1'b0);
        issue(4'd15, 24'd0);
        verdict("R11 opcode 15", 1'b0);
        @(negedge clk);
        check("R11 idle no pulse", {30'd0, cmd_accept, cmd_reject}, 32'd0);

        // protection vectors: R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            wp_pin    = VEC[i].wp;
            sr_lock   = VEC[i].srl;
            bp_invert = VEC[i].inv;
            bp_fine   = VEC[i].fine;
            bp_bottom = VEC[i].bot;
            bp_span   = VEC[i].span;
            issue(4'd1, 24'd0);
            issue(VEC[i].op, VEC[i].addr);
            verdict(tag_of(VEC[i].req), VEC[i].exp);
            check("R4 latch after verdict", {31'd0, wel}, 32'd1);
            if (VEC[i].exp) begin
                done_pulse();
            end else begin
                issue(4'd2, 24'd0);
            end
        end

        // R1 power loss clears latch; R2 exact window edge
        issue(4'd1, 24'd0);
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 power loss clears", {30'd0, wel, pwr_down}, 32'd0);
        pwr_good = 1'b1;
        repeat (PUW - 1) @(negedge clk);
        issue(4'd1, 24'd0);
        verdict("R2 last blocked edge", 1'b0);
        issue(4'd1, 24'd0);
        verdict("R2 first open edge", 1'b1);

        finish_run();
    end

endmodule